// File: doc/BRIEF.md
# Console Keyboard and Display Register Interface

This block is a bus slave that gives software a keyboard input channel and a display output channel through four 32-bit registers placed at consecutive word addresses above a base address. Each channel has a control register that carries a ready flag and an interrupt enable, and a data register that carries one character. The keyboard side latches a character whenever the input strobe pulses. The display side sends a character as a one-cycle start pulse with the byte, and then waits for a completion pulse.

Software either polls the ready flags or enables interrupts. A single interrupt line stays high for as long as some channel is ready and has its enable set. Reading the keyboard character consumes it. Writing a display character starts a transfer. Each of these accesses clears the matching ready flag, so the handler needs no separate acknowledge write.

Top module: `console_mmio`

## Requirements
- R1: After reset, keyboard ready, both interrupt enables, the overrun flag, the interrupt line and the display start pulse are all 0, and display ready is 1.
- R2: A cycle with key_valid high stores key_byte and sets keyboard ready (bit 0 of the keyboard control register at BASE+0x0). Reading BASE+0x4 returns the stored byte in bits 7:0, with all other bits zero.
- R3: A read of the keyboard data register at BASE+0x4 clears keyboard ready, unless a new byte arrives in the same cycle.
- R4: A new byte that arrives while keyboard ready is still set replaces the stored byte and sets the overrun flag, which is bit 2 of BASE+0x0. The overrun flag stays set until reset.
- R5: A write to the display data register at BASE+0xC clears display ready (bit 0 of BASE+0x8). On the next cycle it raises disp_start for exactly one cycle, with disp_byte equal to bits 7:0 of the written data. A read of BASE+0xC returns that byte.
- R6: A disp_done pulse sets display ready, unless a display data write happens in the same cycle.
- R7: In both control registers a write changes only bit 1, the interrupt enable. Writes leave the ready and overrun bits unchanged, and bits 31:3 always read as zero.
- R8: The irq output equals (keyboard ready AND keyboard enable) OR (display ready AND display enable), and it stays high until that condition is cleared.
- R9: An access whose address is not one of the four word-aligned register addresses changes nothing, and a read of such an address returns zero.
- R10: Read data appears on bus_rdata in the cycle after bus_rd is sampled. bus_rdata is zero in a cycle that follows no read.
- R11: When key_valid coincides with a read of the keyboard data register, the read returns the old byte, keyboard ready stays set, and overrun is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| key_valid | input | 1 | Keyboard byte strobe |
| key_byte | input | 8 | Keyboard byte |
| disp_start | output | 1 | One-cycle pulse that starts a display byte |
| disp_byte | output | 8 | Byte being sent to the display |
| disp_done | input | 1 | Display completion pulse |
| irq | output | 1 | Interrupt request, level |

## Verification
All flag changes, the interrupt level and the display start pulse become visible just after the rising edge that samples the stimulus. Read data comes one edge after the read strobe is sampled. The bench drives every input at the falling edge and compares all outputs 1 ns after the next rising edge. It computes the expected values from a model state that it updates with the same same-cycle priorities as the requirements, and it reads the expected read data from that state before applying the update.

// File: rtl/console_pkg.sv
package console_pkg;
   localparam int NUM_REGS = 4;
   localparam int RDY_BIT  = 0;
   localparam int IE_BIT   = 1;
   localparam int OVR_BIT  = 2;

   typedef enum logic [1:0] {
      REG_KEY_CTL  = 2'd0,
      REG_KEY_DAT  = 2'd1,
      REG_DISP_CTL = 2'd2,
      REG_DISP_DAT = 2'd3
   } reg_idx_e;
endpackage

// File: rtl/console_decode.sv
module console_decode
   import console_pkg::*;
#(
   parameter int               ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE  = '0
)(
   input  logic [ADDR_W-1:0]   addr,
   input  logic                rd,
   input  logic                wr,
   output logic [NUM_REGS-1:0] rd_sel,
   output logic [NUM_REGS-1:0] wr_sel
);
   localparam int IDX_LO = 2;
   localparam int IDX_HI = IDX_LO + $clog2(NUM_REGS) - 1;

   logic hit;
   assign hit = (addr[ADDR_W-1:IDX_HI+1] == BASE[ADDR_W-1:IDX_HI+1]) &&
                (addr[IDX_LO-1:0] == '0);

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
      assign rd_sel[g] = rd && hit && (addr[IDX_HI:IDX_LO] == g[IDX_HI-IDX_LO:0]);
      assign wr_sel[g] = wr && hit && (addr[IDX_HI:IDX_LO] == g[IDX_HI-IDX_LO:0]);
   end
endmodule

// File: rtl/console_kbd_chan.sv
module console_kbd_chan #(
   parameter int CHAR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_byte,
   input  logic              rd_data,
   input  logic              wr_ctrl,
   input  logic              wr_ie,
   output logic              ready,
   output logic              ie,
   output logic              ovr,
   output logic [CHAR_W-1:0] data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready <= 1'b0;
         ie    <= 1'b0;
         ovr   <= 1'b0;
         data  <= '0;
      end else begin
         if (wr_ctrl) ie <= wr_ie;
         if (key_valid) begin
            data  <= key_byte;
            ready <= 1'b1;
            if (ready && !rd_data) ovr <= 1'b1;
         end else if (rd_data) begin
            ready <= 1'b0;
         end
      end
   end

   assert_ovr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovr |=> ovr);
   assert_push_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> ready);
   assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !key_valid) |=> !ready);
   assert_coincide_no_ovr_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && rd_data && !ovr) |=> (ready && !ovr));
endmodule

// File: rtl/console_disp_chan.sv
module console_disp_chan #(
   parameter int CHAR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_data,
   input  logic [CHAR_W-1:0] wdata_byte,
   input  logic              wr_ctrl,
   input  logic              wr_ie,
   input  logic              done,
   output logic              ready,
   output logic              ie,
   output logic              start,
   output logic [CHAR_W-1:0] byte_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ready  <= 1'b1;
         ie     <= 1'b0;
         start  <= 1'b0;
         byte_o <= '0;
      end else begin
         if (wr_ctrl) ie <= wr_ie;
         start <= wr_data;
         if (wr_data) begin
            byte_o <= wdata_byte;
            ready  <= 1'b0;
         end else if (done) begin
            ready <= 1'b1;
         end
      end
   end

   assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> (start && !ready && byte_o == $past(wdata_byte)));
   assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !$past(wr_data, 2)) |=> !start || $past(wr_data));
   assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_data) |=> ready);
endmodule

// File: rtl/console_mmio.sv
module console_mmio
   import console_pkg::*;
#(
   parameter int          ADDR_W    = 32,
   parameter int          DATA_W    = 32,
   parameter int          CHAR_W    = 8,
   parameter logic [31:0] BASE      = 32'hFFFF_0000,
   parameter bit          RDATA_REG = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              key_valid,
   input  logic [7:0]        key_byte,
   output logic              disp_start,
   output logic [7:0]        disp_byte,
   input  logic              disp_done,
   output logic              irq
);
   if (DATA_W != 32 || ADDR_W != 32 || CHAR_W != 8) begin : g_bad_width
      $error("console_mmio: port widths are fixed at 32/32/8");
   end
   if (BASE[3:0] != 4'h0) begin : g_bad_base
      $error("console_mmio: BASE must be aligned to 16 bytes");
   end
   if (OVR_BIT >= DATA_W || CHAR_W > DATA_W) begin : g_bad_layout
      $error("console_mmio: control fields do not fit the data width");
   end

   logic [NUM_REGS-1:0] rd_sel, wr_sel;
   logic k_ready, k_ie, k_ovr, d_ready, d_ie;
   logic [CHAR_W-1:0] k_data;
   logic [DATA_W-1:0] rd_mux;

   console_decode #(.ADDR_W(ADDR_W), .BASE(BASE[ADDR_W-1:0])) u_dec (
      .addr(bus_addr), .rd(bus_rd), .wr(bus_wr),
      .rd_sel(rd_sel), .wr_sel(wr_sel)
   );

   console_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
      .clk(clk), .rst_n(rst_n),
      .key_valid(key_valid), .key_byte(key_byte),
      .rd_data(rd_sel[REG_KEY_DAT]),
      .wr_ctrl(wr_sel[REG_KEY_CTL]), .wr_ie(bus_wdata[IE_BIT]),
      .ready(k_ready), .ie(k_ie), .ovr(k_ovr), .data(k_data)
   );

   console_disp_chan #(.CHAR_W(CHAR_W)) u_disp (
      .clk(clk), .rst_n(rst_n),
      .wr_data(wr_sel[REG_DISP_DAT]), .wdata_byte(bus_wdata[CHAR_W-1:0]),
      .wr_ctrl(wr_sel[REG_DISP_CTL]), .wr_ie(bus_wdata[IE_BIT]),
      .done(disp_done),
      .ready(d_ready), .ie(d_ie), .start(disp_start), .byte_o(disp_byte)
   );

   always_comb begin
      rd_mux = '0;
      unique case (1'b1)
         rd_sel[REG_KEY_CTL]: begin
            rd_mux[RDY_BIT] = k_ready;
            rd_mux[IE_BIT]  = k_ie;
            rd_mux[OVR_BIT] = k_ovr;
         end
         rd_sel[REG_KEY_DAT]:  rd_mux[CHAR_W-1:0] = k_data;
         rd_sel[REG_DISP_CTL]: begin
            rd_mux[RDY_BIT] = d_ready;
            rd_mux[IE_BIT]  = d_ie;
         end
         rd_sel[REG_DISP_DAT]: rd_mux[CHAR_W-1:0] = disp_byte;
         default: rd_mux = '0;
      endcase
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_mux;
      end
      assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |=> (bus_rdata == '0));
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end

   assign irq = (k_ready & k_ie) | (d_ready & d_ie);

   assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_sel) && $onehot0(wr_sel));
   assert_irq_has_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (k_ie || d_ie));
   assert_irq_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> ((!k_ready || !k_ie) && (!d_ready || !d_ie)));
   assert_ctl_write_keeps_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sel[REG_KEY_CTL] && !key_valid && !rd_sel[REG_KEY_DAT]) |=> $stable(k_ready));
endmodule

// File: tb/console_mmio_tb_top.sv
module console_mmio_tb_top;
   localparam logic [31:0] BASE = 32'hFFFF_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [31:0] bus_addr = '0, bus_wdata = '0;
   logic bus_rd = 1'b0, bus_wr = 1'b0;
   logic [31:0] bus_rdata;
   logic key_valid = 1'b0;
   logic [7:0] key_byte = '0;
   logic disp_start;
   logic [7:0] disp_byte;
   logic disp_done = 1'b0;
   logic irq;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   console_mmio dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .key_valid(key_valid), .key_byte(key_byte), .disp_start(disp_start),
      .disp_byte(disp_byte), .disp_done(disp_done), .irq(irq)
   );

   // bench model state
   logic m_kr, m_kie, m_ov, m_dr, m_die;
   logic [7:0] m_kb, m_db;

   task automatic check(input logic ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mread(input logic [31:0] a);
      case (a)
         BASE:        return {29'd0, m_ov, m_kie, m_kr};
         BASE + 4:    return {24'd0, m_kb};
         BASE + 8:    return {30'd0, m_die, m_dr};
         BASE + 12:   return {24'd0, m_db};
         default:     return 32'd0;
      endcase
   endfunction

   function automatic string rtag(input logic rd, input logic [31:0] a);
      if (!rd) return "R10";
      case (a)
         BASE, BASE + 8: return "R7";
         BASE + 4:       return "R2";
         BASE + 12:      return "R5";
         default:        return "R9";
      endcase
   endfunction

   task automatic cyc(input logic rd, input logic wr, input logic [31:0] a,
                      input logic [31:0] wd, input logic kv, input logic [7:0] kb,
                      input logic dn, input string tag);
      logic [31:0] exp_rd;
      logic exp_start;
      logic [7:0] exp_byte;
      logic rd_kd;
      string t;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
      key_valid = kv; key_byte = kb; disp_done = dn;
      exp_rd = rd ? mread(a) : 32'd0;
      rd_kd = rd && (a == BASE + 4);
      if (kv) begin
         m_kb = kb;
         if (m_kr && !rd_kd) m_ov = 1'b1;
         m_kr = 1'b1;
      end else if (rd_kd) m_kr = 1'b0;
      if (wr && a == BASE)     m_kie = wd[1];
      if (wr && a == BASE + 8) m_die = wd[1];
      exp_start = wr && (a == BASE + 12);
      if (exp_start) begin
         m_dr = 1'b0; m_db = wd[7:0];
      end else if (dn) m_dr = 1'b1;
      exp_byte = m_db;
      @(posedge clk);
      #1;
      t = (tag != "") ? tag : rtag(rd, a);
      check(bus_rdata === exp_rd, t, bus_rdata, exp_rd);
      check(irq === ((m_kr & m_kie) | (m_dr & m_die)), "R8", {31'd0, irq},
            {31'd0, (m_kr & m_kie) | (m_dr & m_die)});
      check(disp_start === exp_start, "R5", {31'd0, disp_start}, {31'd0, exp_start});
      if (exp_start) check(disp_byte === exp_byte, "R5", {24'd0, disp_byte}, {24'd0, exp_byte});
   endtask

   task automatic idle();
      cyc(1'b0, 1'b0, 32'd0, 32'd0, 1'b0, 8'd0, 1'b0, "");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [31:0] seed;
      seed = $urandom(32'd2024);
      m_kr = 0; m_kie = 0; m_ov = 0; m_dr = 1; m_die = 0; m_kb = 0; m_db = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      // R1 reset state
      check(irq === 1'b0 && disp_start === 1'b0, "R1", {30'd0, irq, disp_start}, 32'd0);
      cyc(1, 0, BASE, 0, 0, 0, 0, "R1");
      cyc(1, 0, BASE + 8, 0, 0, 0, 0, "R1");
      // R2 / R3 key in, read, cleared
      cyc(0, 0, 0, 0, 1, 8'h41, 0, "");
      cyc(1, 0, BASE + 4, 0, 0, 0, 0, "R2");
      cyc(1, 0, BASE, 0, 0, 0, 0, "R3");
      // R4 overrun
      cyc(0, 0, 0, 0, 1, 8'h11, 0, "");
      cyc(0, 0, 0, 0, 1, 8'h22, 0, "");
      cyc(1, 0, BASE, 0, 0, 0, 0, "R4");
      cyc(1, 0, BASE + 4, 0, 0, 0, 0, "R4");
      // R7 control writes touch bit 1 only
      cyc(0, 1, BASE, 32'hFFFF_FFFD, 0, 0, 0, "");
      cyc(1, 0, BASE, 0, 0, 0, 0, "R7");
      cyc(0, 1, BASE + 8, 32'hFFFF_FFFF, 0, 0, 0, "");
      cyc(1, 0, BASE + 8, 0, 0, 0, 0, "R7");
      // R5 / R6 / R8 display send with interrupt
      cyc(0, 1, BASE + 12, 32'hABCD_EF5A, 0, 0, 0, "");
      idle();
      cyc(1, 0, BASE + 12, 0, 0, 0, 0, "R5");
      cyc(0, 0, 0, 0, 0, 0, 1, "");
      cyc(1, 0, BASE + 8, 0, 0, 0, 0, "R6");
      // R11 byte arrives during data read
      cyc(0, 0, 0, 0, 1, 8'h31, 0, "");
      cyc(1, 0, BASE + 4, 0, 1, 8'h32, 0, "R11");
      cyc(1, 0, BASE, 0, 0, 0, 0, "R11");
      // R9 out-of-range and unaligned accesses
      cyc(0, 1, BASE + 16, 32'h0, 0, 0, 0, "");
      cyc(0, 1, BASE + 2, 32'h0, 0, 0, 0, "");
      cyc(0, 1, BASE - 4, 32'h0, 0, 0, 0, "");
      cyc(1, 0, BASE, 0, 0, 0, 0, "R9");
      cyc(1, 0, BASE + 20, 0, 0, 0, 0, "R9");
      cyc(1, 0, BASE + 5, 0, 0, 0, 0, "R9");
      idle();
      // constrained random mix
      for (int i = 0; i < 600; i++) begin
         int op;
         logic kv;
         logic [7:0] kb;
         op = $urandom_range(0, 8);
         kv = ($urandom_range(0, 3) == 0);
         kb = 8'($urandom);
         case (op)
            0: cyc(0, 0, 0, 0, 1, kb, 0, "");
            1: cyc(1, 0, BASE + 4, 0, kv, kb, 0, "");
            2: cyc(1, 0, BASE, 0, kv, kb, 0, "");
            3: cyc(0, 1, BASE, $urandom, kv, kb, 0, "");
            4: cyc(1, 0, BASE + 8, 0, 0, 0, $urandom_range(0, 1) == 1, "");
            5: cyc(0, 1, BASE + 8, $urandom, 0, 0, 0, "");
            6: cyc(0, 1, BASE + 12, $urandom, 0, 0, $urandom_range(0, 1) == 1, "");
            7: cyc(1, 0, BASE + 12, 0, 0, 0, 1, "");
            default: cyc($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                         BASE + 16 + 32'($urandom_range(0, 63)), $urandom, 0, 0, 0, "R9");
         endcase
      end
      idle();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule